// File: doc/BRIEF.md
# Dead-Time Gate Drive Controller

This block converts one pulse-width command into a pair of gate enables for the upper and lower switch of a synchronous buck power stage. The command reaches the block as two comparator flags: one says the input is above the high threshold, the other says it is below the low threshold. When the command changes level, the enable that is on turns off on the next clock edge. The opposite enable turns on only after a dead time, counted in clock cycles, and only if the command has stayed at its new level for that whole time.

An input that stays between the thresholds is treated as a floating driver. The same applies when both flags are set, which is not a valid level. If the input remains in that state for longer than a qualification time, counted in cycles, both enables are forced off and a status flag is raised. Normal switching returns only after the input has stayed at a valid level for longer than the same qualification time. The dead time then starts again from zero. Both timings come from input ports. The block leaves reset with both enables low, in the forced-off state.

Top module: `gate_deadtime_ctrl`

## Requirements
- R1: During and right after reset, hs_en and ls_en are 0 and float_off is 1.
- R2: A valid-high sample (above_hi=1, below_lo=0) makes ls_en 0 from the next clock edge, whatever the dead time is.
- R3: hs_en becomes 1 on the edge that takes the (dead_cycles+1)-th consecutive sample whose command is high. A high pulse shorter than that produces no hs_en pulse.
- R4: A valid-low sample (above_hi=0, below_lo=1) makes hs_en 0 from the next clock edge.
- R5: ls_en becomes 1 on the edge that takes the (dead_cycles+1)-th consecutive sample whose command is low. A shorter low pulse produces no ls_en pulse.
- R6: hs_en and ls_en are never 1 in the same cycle.
- R7: A mid-level sample (both flags 0) keeps the last valid command. After qual_cycles+1 consecutive mid-level samples, float_off becomes 1 and both enables become 0.
- R8: While float_off is 1, it clears after qual_cycles+1 consecutive valid samples. The dead-time count starts from zero at that edge, so neither enable turns on then unless dead_cycles is 0.
- R9: A sample with both flags set to 1 counts as mid-level for both R7 and R8.
- R10: float_off is 1 exactly while the block is in the forced-off state, and both enables are 0 while it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all timing counters |
| rst_n | input | 1 | Active-low synchronous reset |
| above_hi | input | 1 | Comparator flag: input is above the high threshold |
| below_lo | input | 1 | Comparator flag: input is below the low threshold |
| dead_cycles | input | CW | Dead time, in clock cycles |
| qual_cycles | input | CW | Floating-input qualification time, in clock cycles |
| hs_en | output | 1 | Registered upper-switch gate enable |
| ls_en | output | 1 | Registered lower-switch gate enable |
| float_off | output | 1 | Forced-off state caused by a floating or invalid input |

## Verification
The assertions check the following on every cycle:
- the two enables are never on together;
- a valid sample of either level turns the opposing enable off on the next edge;
- while the dead time is non-zero, an enable never rises straight after the other one was on;
- the forced-off state is entered only from a mid-level sample and left only from a valid sample.

The exact cycle in which an enable rises needs the bench's reference model, which is compared on every clock. The same holds for the rejection of short pulses, the count at which the floating state qualifies and the restart of the dead time after recovery.

// File: rtl/gate_deadtime_ctrl.sv
module gate_deadtime_ctrl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          above_hi,
  input  logic          below_lo,
  input  logic [CW-1:0] dead_cycles,
  input  logic [CW-1:0] qual_cycles,
  output logic          hs_en,
  output logic          ls_en,
  output logic          float_off
);

  logic          mid, cur, qual, done, off_n, restart;
  logic          lvl;
  logic [CW-1:0] qcnt, run, run_n;

  // flags equal: either floating between thresholds or an invalid pair
  assign mid     = (above_hi == below_lo);
  assign cur     = mid ? lvl : above_hi;
  assign qual    = float_off ? !mid : mid;
  assign done    = qual && (qcnt == qual_cycles);
  assign off_n   = float_off ^ done;
  assign restart = off_n || float_off || (cur != lvl);
  assign run_n   = restart ? '0 : ((run >= dead_cycles) ? run : run + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      float_off <= 1'b1;
      qcnt      <= '0;
      lvl       <= 1'b0;
      run       <= '0;
      hs_en     <= 1'b0;
      ls_en     <= 1'b0;
    end else begin
      float_off <= off_n;
      qcnt      <= (qual && !done) ? qcnt + 1'b1 : '0;
      lvl       <= cur;
      run       <= run_n;
      hs_en     <= !off_n &&  cur && (run_n >= dead_cycles);
      ls_en     <= !off_n && !cur && (run_n >= dead_cycles);
    end
  end

  p_never_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  p_ls_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (above_hi && !below_lo) |=> !ls_en);

  p_hs_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (below_lo && !above_hi) |=> !hs_en);

  p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_en) && $past(dead_cycles) != '0) |-> $past(!ls_en));

  p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ls_en) && $past(dead_cycles) != '0) |-> $past(!hs_en));

  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    float_off |-> (!hs_en && !ls_en));

  p_enter_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(float_off) |-> $past(above_hi == below_lo));

  p_exit_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(float_off) |-> $past(above_hi != below_lo));

endmodule

// File: tb/gate_deadtime_ctrl_tb_top.sv
module gate_deadtime_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic above_hi = 1'b0, below_lo = 1'b0;
  logic [CW-1:0] dead_cycles = 8'd3, qual_cycles = 8'd4;
  logic hs_en, ls_en, float_off;

  int n_checks = 0, n_fail = 0;
  bit done_flag = 0;

  gate_deadtime_ctrl #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .above_hi(above_hi), .below_lo(below_lo),
    .dead_cycles(dead_cycles), .qual_cycles(qual_cycles),
    .hs_en(hs_en), .ls_en(ls_en), .float_off(float_off));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: streak counters and command age
  int m_off = 1, m_hs = 0, m_ls = 0, m_lvl = 0, m_age = 0, m_mid_run = 0, m_val_run = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_off = 1; m_hs = 0; m_ls = 0; m_lvl = 0; m_age = 0; m_mid_run = 0; m_val_run = 0;
    end else begin
      int is_mid, now_lvl, left_off;
      is_mid = (above_hi == below_lo);
      now_lvl = is_mid ? m_lvl : int'(above_hi);
      left_off = 0;
      if (m_off) begin
        m_val_run = is_mid ? 0 : m_val_run + 1;
        if (m_val_run == int'(qual_cycles) + 1) begin m_off = 0; m_val_run = 0; left_off = 1; end
      end else begin
        m_mid_run = is_mid ? m_mid_run + 1 : 0;
        if (m_mid_run == int'(qual_cycles) + 1) begin m_off = 1; m_mid_run = 0; end
      end
      if (m_off || left_off || now_lvl != m_lvl) m_age = 0;
      else if (m_age < 100000) m_age++;
      m_lvl = now_lvl;
      m_hs = (!m_off && now_lvl == 1 && m_age >= int'(dead_cycles));
      m_ls = (!m_off && now_lvl == 0 && m_age >= int'(dead_cycles));
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done_flag) begin
    chk(int'(hs_en) == m_hs, "R3 hs_en vs model", int'(hs_en), m_hs);
    chk(int'(ls_en) == m_ls, "R5 ls_en vs model", int'(ls_en), m_ls);
    chk(int'(float_off) == m_off, "R10 float_off vs model", int'(float_off), m_off);
    chk(!(hs_en && ls_en), "R6 both enables", int'(hs_en && ls_en), 0);
  end

  task automatic drive(input logic h, input logic l, input int n);
    above_hi = h; below_lo = l;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(hs_en == 0, "R1 hs_en in reset", int'(hs_en), 0);
    chk(ls_en == 0, "R1 ls_en in reset", int'(ls_en), 0);
    chk(float_off == 1, "R1 float_off in reset", int'(float_off), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(float_off == 1, "R1 float_off after reset", int'(float_off), 1);

    drive(1, 0, 12);
    chk(hs_en == 1, "R3 hs_en after dead time", int'(hs_en), 1);
    drive(0, 1, 1);
    chk(hs_en == 0, "R4 hs_en drops at once", int'(hs_en), 0);
    chk(ls_en == 0, "R5 ls_en waits dead time", int'(ls_en), 0);
    drive(0, 1, 11);
    chk(ls_en == 1, "R5 ls_en after dead time", int'(ls_en), 1);
    drive(1, 0, 1);
    chk(ls_en == 0, "R2 ls_en drops at once", int'(ls_en), 0);
    drive(0, 1, 12);

    // short high pulse: 2 samples < dead+1
    drive(1, 0, 1);
    chk(hs_en == 0, "R3 short pulse no turn-on", int'(hs_en), 0);
    drive(1, 0, 1);
    chk(hs_en == 0, "R3 short pulse no turn-on", int'(hs_en), 0);
    drive(0, 1, 1);
    chk(hs_en == 0, "R3 short pulse no turn-on", int'(hs_en), 0);
    drive(0, 1, 12);

    drive(0, 0, 3);
    chk(ls_en == 1, "R7 short mid keeps command", int'(ls_en), 1);
    chk(float_off == 0, "R7 short mid not qualified", int'(float_off), 0);
    drive(0, 1, 3);
    drive(0, 0, 7);
    chk(float_off == 1, "R7 long mid forces off", int'(float_off), 1);
    chk(ls_en == 0, "R7 long mid ls_en off", int'(ls_en), 0);

    drive(0, 1, 4);
    chk(float_off == 1, "R8 exit needs qual+1 samples", int'(float_off), 1);
    drive(0, 1, 1);
    chk(float_off == 0, "R8 exit after qual+1 samples", int'(float_off), 0);
    chk(ls_en == 0, "R8 dead time restarts on exit", int'(ls_en), 0);
    drive(0, 1, 10);

    drive(1, 1, 7);
    chk(float_off == 1, "R9 both flags treated as mid", int'(float_off), 1);
    chk(hs_en == 0 && ls_en == 0, "R9 both flags enables off", int'(hs_en | ls_en), 0);

    dead_cycles = 8'd1; qual_cycles = 8'd2;
    drive(1, 0, 10);
    chk(hs_en == 1, "R3 hs_en with dead=1", int'(hs_en), 1);

    for (int i = 0; i < 600; i++) begin
      int k, len;
      k = $urandom_range(0, 9);
      len = $urandom_range(1, 8);
      if (k < 4) drive(1, 0, len);
      else if (k < 8) drive(0, 1, len);
      else if (k == 8) drive(0, 0, len);
      else drive(1, 1, len);
    end
    finish_run();
  end
endmodule